// File: doc/BRIEF.md
# Eight-Bit ALU with Condition Flags

This block is a purely combinational arithmetic logic unit for an 8-bit datapath. It takes two operands and an operation code. In the same cycle it returns an 8-bit result and a 4-bit condition bus that holds sign, zero, overflow and carry. It supports eight operations:

- add and subtract
- bitwise OR and AND
- complement of the first operand
- arithmetic shift right
- arithmetic shift left
- exchange of the two halves of the first operand

Each operation has its own rule for the overflow and carry bits. The enclosing core captures the condition bus in its own register. Sign and zero always describe the result that is presented.

The operation code is 4 bits wide. Codes 0 to 7 select ADD, SUB, OR, AND, NOT, ASR, ASL and SWP in that order. Codes 8 to 15 are unused.

Top module: `alu8`

## Requirements
- R1: flags_o bit 3 is sign, bit 2 is zero, bit 1 is overflow and bit 0 is carry.
- R2: ADD (code 0) gives (a_i + b_i) mod 256. Carry is the unsigned carry out. Overflow is set when both operands have equal bit 7 and the result bit 7 differs from it.
- R3: SUB (code 1) gives (a_i - b_i) mod 256. Carry is set when a_i < b_i unsigned, which is a borrow. Overflow is set when the operand bit 7 values differ and the result bit 7 differs from a_i bit 7.
- R4: OR (code 2), AND (code 3) and NOT (code 4, ~a_i) give the bitwise result, with overflow and carry both 0.
- R5: ASR (code 5) gives {a_i[7], a_i[7:1]}. Carry equals a_i[0] and overflow is 0.
- R6: ASL (code 6) gives {a_i[6:0], 0}. Carry equals a_i[6] and overflow equals a_i[7] XOR a_i[6].
- R7: SWP (code 7) gives {a_i[3:0], a_i[7:4]}, with overflow and carry both 0.
- R8: For every code, sign equals res_o[7] and zero is set exactly when res_o is 0.
- R9: For NOT, ASR, ASL and SWP, b_i has no effect on res_o or flags_o.
- R10: Codes 8 to 15 give res_o = 0 and flags_o = 4'b0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand, and the only operand of the unary and shift operations |
| b_i | input | 8 | Second operand |
| op_i | input | 4 | Operation code |
| res_o | output | 8 | Operation result |
| flags_o | output | 4 | Condition bits {sign, zero, overflow, carry} |

## Verification
The immediate assertions assume that op_i, a_i and b_i hold known two-state values that have settled before the combinational logic is evaluated. They say nothing about intermediate values during glitches. The bench meets this by changing the inputs only just after a rising clock edge and reading the outputs half a period later. It sweeps all sixteen codes, including the unused ones, over the operand extremes 0x00, 0x01, 0x7F, 0x80 and 0xFF, and then over random operand pairs. For the operations that ignore b_i, it applies the same a_i with two complementary b_i values and compares the two outputs.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_OR  = 4'd2,
    OP_AND = 4'd3,
    OP_NOT = 4'd4,
    OP_ASR = 4'd5,
    OP_ASL = 4'd6,
    OP_SWP = 4'd7
  } alu_op_e;

  // field order sets bit positions: s is bit 3, c is bit 0
  typedef struct packed {
    logic s;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         v_o,
  output logic         c_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   sum;

  // subtract as a + ~b + 1 on the same adder
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign res_o = sum[W-1:0];
  // carry-out of a + ~b + 1 is the inverse of borrow
  assign c_o   = sub_i ? ~sum[W] : sum[W];
  assign v_o   = (a_i[MSB] == b_eff[MSB]) && (res_o[MSB] != a_i[MSB]);

  always_comb begin
    if (sub_i)
      AST_SUB_RESULT: assert (res_o == W'(a_i - b_i)); // R3
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic import alu8_pkg::*; #(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic [W-1:0]    res_o
);
  localparam int HALF = W / 2;

  logic [W-1:0] swapped;
  assign swapped = {a_i[HALF-1:0], a_i[W-1:HALF]};

  always_comb begin
    case (op_i)
      OP_OR:   res_o = a_i | b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_NOT:  res_o = ~a_i;
      OP_SWP:  res_o = swapped;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == OP_SWP)
      AST_SWAP_ROUNDTRIP: assert ({res_o[HALF-1:0], res_o[W-1:HALF]} == a_i); // R7
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         left_i,
  output logic [W-1:0] res_o,
  output logic         v_o,
  output logic         c_o
);
  localparam int MSB = W - 1;

  always_comb begin
    if (left_i) begin
      res_o = {a_i[MSB-1:0], 1'b0};
      c_o   = a_i[MSB-1];
      v_o   = a_i[MSB] ^ a_i[MSB-1];
    end else begin
      res_o = {a_i[MSB], a_i[MSB:1]};
      c_o   = a_i[0];
      v_o   = 1'b0;
    end
  end

  always_comb begin
    if (!left_i)
      AST_ASR_SIGN_KEPT: assert (res_o[MSB] == a_i[MSB]); // R5
  end
endmodule

// File: rtl/alu8.sv
module alu8 import alu8_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    res_o,
  output logic [3:0]      flags_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] ar_res, lg_res, sh_res, res;
  logic         ar_v, ar_c, sh_v, sh_c, v, c;
  alu_flags_t   flags;

  alu8_arith #(.W(W)) u_arith (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (op_i == OP_SUB),
    .res_o (ar_res),
    .v_o   (ar_v),
    .c_o   (ar_c)
  );

  alu8_logic #(.W(W)) u_logic (
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (lg_res)
  );

  alu8_shift #(.W(W)) u_shift (
    .a_i    (a_i),
    .left_i (op_i == OP_ASL),
    .res_o  (sh_res),
    .v_o    (sh_v),
    .c_o    (sh_c)
  );

  always_comb begin
    res = '0;
    v   = 1'b0;
    c   = 1'b0;
    case (op_i)
      OP_ADD, OP_SUB: begin
        res = ar_res;
        v   = ar_v;
        c   = ar_c;
      end
      OP_OR, OP_AND, OP_NOT, OP_SWP: res = lg_res;
      OP_ASR, OP_ASL: begin
        res = sh_res;
        v   = sh_v;
        c   = sh_c;
      end
      default: ;
    endcase
  end

  assign flags.s = res[MSB];
  assign flags.z = (res == '0);
  assign flags.v = v;
  assign flags.c = c;
  assign res_o   = res;
  assign flags_o = flags;

  always_comb begin
    if (op_i == OP_ADD)
      AST_ADD_CARRY: assert (flags_o[0] == (({1'b0, a_i} + {1'b0, b_i}) > (W+1)'({W{1'b1}}))); // R2
    if (op_i == OP_SUB)
      AST_SUB_BORROW: assert (flags_o[0] == (a_i < b_i)); // R3
    if (op_i inside {OP_OR, OP_AND, OP_NOT})
      AST_NO_OVERFLOW: assert (flags_o[1:0] == 2'b00); // R4
    if (op_i == OP_ASL)
      AST_ASL_CARRY: assert (flags_o[0] == a_i[MSB-1] && res_o[0] == 1'b0); // R6
    if (op_i > OP_SWP)
      AST_UNUSED_ZERO: assert (res_o == '0 && flags_o == 4'b0100); // R10
  end
endmodule

// File: tb/alu8_tb.sv
module alu8_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a, b, res;
  logic [3:0] op, flags;
  int checks = 0;
  int fails  = 0;

  always #5ns clk = ~clk;

  alu8 u_dut (
    .a_i(a), .b_i(b), .op_i(op), .res_o(res), .flags_o(flags)
  );

  function automatic logic [11:0] ref_calc(int code, int x, int y);
    int r = 0;
    bit v = 0, c = 0, x7, y7, r7;
    x7 = x[7];
    y7 = y[7];
    case (code)
      0: begin r = (x + y) & 255; c = (x + y) > 255; end
      1: begin r = (x - y) & 255; c = x < y; end
      2: r = x | y;
      3: r = x & y;
      4: r = (~x) & 255;
      5: begin r = (x >> 1) | (x & 128); c = x[0]; end
      6: begin r = (x << 1) & 255; c = x[6]; v = x[7] != x[6]; end
      7: r = ((x & 15) << 4) | (x >> 4);
      default: r = 0;
    endcase
    r7 = r[7];
    if (code == 0) v = (x7 == y7) && (r7 != x7);
    if (code == 1) v = (x7 != y7) && (r7 != x7);
    return {r[7:0], r7, r == 0, v, c};
  endfunction

  function automatic string tag_of(int code);
    case (code)
      0: return "R2";
      1: return "R3";
      2, 3, 4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%02h b=%02h actual=%03h expected=%03h", tag, op, a, b, act, exp);
    end
  endtask

  task automatic run(int code, int x, int y);
    @(posedge clk);
    op = 4'(code); a = 8'(x); b = 8'(y);
    @(negedge clk);
    check(tag_of(code), {res, flags}, ref_calc(code, x, y));
    // R8: sign and zero follow the result
    check("R8", {8'h0, flags[3:2], 2'b0}, {8'h0, res[7], res == 8'h0, 2'b0});
  endtask

  // R9: b_i must not change the outcome of unary and shift codes
  task automatic r9_check(int code, int x, int y);
    logic [11:0] first;
    @(posedge clk);
    op = 4'(code); a = 8'(x); b = 8'(y);
    @(negedge clk);
    first = {res, flags};
    @(posedge clk);
    b = ~8'(y);
    @(negedge clk);
    check("R9", {res, flags}, first);
  endtask

  initial begin
    int corner [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    op = 4'd0; a = 8'h00; b = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", {res, flags}, {8'h00, 4'b0100});
    rst_ni = 1'b1;
    // R1: 0x80 + 0x80 gives zero, overflow and carry in bits 2,1,0
    run(0, 8'h80, 8'h80);
    check("R1", {8'h0, flags}, {8'h0, 4'b0111});
    // R1: sign in bit 3
    run(1, 8'h00, 8'h01);
    check("R1", {8'h0, flags}, {8'h0, 4'b1001});
    for (int k = 0; k < 16; k++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run(k, corner[i], corner[j]);
    for (int n = 0; n < 2000; n++)
      run(int'($urandom_range(15)), int'($urandom_range(255)), int'($urandom_range(255)));
    for (int k = 4; k < 8; k++)
      for (int n = 0; n < 20; n++)
        r9_check(k, int'($urandom_range(255)), int'($urandom_range(255)));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule